// File: doc/BRIEF.md
# Tree-structured forward/backward state metric engine

This block produces the forward and backward path metrics of a four-state trellis over a window of N steps, with N a power of two. It does not run the usual step-by-step recursions. Instead it merges partial results as a balanced binary tree: every stage combines pairs of adjacent sub-intervals. For each sub-interval it keeps the best-path metric matrices from the left edge to every interior point, from every interior point to the right edge, and across the whole sub-interval. The result is ready log2(N) stages after the inputs are loaded, where a sequential recursion needs N add-compare-select steps.

The user presents N one-step transition metric matrices, an initial forward vector (metrics at time 0) and an initial backward vector (metrics at time N), and pulses `start_i`. The engine captures these on that edge and runs one tree stage per clock. It then raises `done_o` together with normalised forward and backward vectors for every time index 0..N. Metrics use min-sum arithmetic: a smaller value is better, and the all-ones code stands for an impossible path.

Top module: `tsiso_metric_tree`

## Requirements
- R1: After a run, forward vector t (t = 0..N) equals the min-sum recursion fwd[t+1][j] = min over i of (fwd[t][i] + g[t][i][j]) started from the initial forward vector, then normalised (R4). Vector t occupies bits (t*4+s)*W of `fwd_o` for state s, and g[k][i][j] occupies bits ((k*4+i)*4+j)*W of `gamma_i`.
- R2: After a run, backward vector t equals bwd[t][i] = min over j of (g[t][i][j] + bwd[t+1][j]) started from the initial backward vector at index N, then normalised, with the same packing in `bwd_o`.
- R3: `done_o` goes low on the edge that accepts a start and rises exactly log2(N) clock edges later. It then stays high until the next accepted start.
- R4: Every output vector is normalised. Its smallest entry is subtracted from each finite entry, so the minimum is 0. Entries equal to the all-ones code stay all-ones, and a vector of all-ones stays all-ones.
- R5: Additions saturate. A sum that reaches or passes the all-ones code, or that has an all-ones operand, yields the all-ones code. A transition given the all-ones metric is therefore never chosen.
- R6: A `start_i` that arrives while a run is in progress is ignored. The run finishes on time with the results of the inputs it originally captured.
- R7: Inputs are sampled only on the edge that accepts a start. Changes to them afterwards do not affect the result.
- R8: The output vectors change only on the edge where `done_o` rises, and they hold their values until the next completion.
- R9: While `rst_n` is low at a clock edge, `done_o` is cleared and all output vectors are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a run (when idle) |
| gamma_i | input | N*4*4*W | One-step transition metrics g[k][from][to] |
| fwd_init_i | input | 4*W | Forward metrics at time 0 |
| bwd_init_i | input | 4*W | Backward metrics at time N |
| done_o | output | 1 | Results valid, held until next accepted start |
| fwd_o | output | (N+1)*4*W | Normalised forward vectors for t = 0..N |
| bwd_o | output | (N+1)*4*W | Normalised backward vectors for t = 0..N |

## Verification
Suppose a span matrix merges with the wrong neighbour, or a stage swaps which half passes through. Then only some time indices go wrong: the right half of the forward vectors or the left half of the backward vectors from that stage onward. So every vector is compared, not a sample of them. A stage counter that is off by one shows up on the very edge `done_o` rises, as either a shifted completion time or vectors built from unmerged matrices. This is why the completion edge is checked exactly. A capture fault shows up only when inputs change during a run, so runs with scrambled inputs and ignored restarts are part of the stimulus.

// File: rtl/tsiso_pkg.sv
// Package: shared types for the tree-structured state metric engine.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package tsiso_pkg;

    // Run phase of the engine controller.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

endpackage

// File: rtl/tsiso_mm_fuse.sv
// Module: min-sum product of two span matrices, y[i][j] = min_k (a[i][k] + b[k][j]).
// Assumes the all-ones code means "no path"; additions saturate to it.
module tsiso_mm_fuse #(
    parameter int NS = 4,
    parameter int W  = 8
) (
    input  logic [W-1:0] a_i [NS][NS],
    input  logic [W-1:0] b_i [NS][NS],
    output logic [W-1:0] y_o [NS][NS]
);
    localparam logic [W-1:0] INF = '1;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (x == INF || y == INF || s >= {1'b0, INF}) return INF;
        return s[W-1:0];
    endfunction

    // Marginalise the shared midpoint state for every (left, right) pair.
    always_comb begin
        logic [W-1:0] best;
        logic [W-1:0] cand;
        for (int i = 0; i < NS; i++) begin
            for (int j = 0; j < NS; j++) begin
                best = INF;
                for (int k = 0; k < NS; k++) begin
                    cand = sat_add(a_i[i][k], b_i[k][j]);
                    if (cand < best) best = cand;
                end
                y_o[i][j] = best;
            end
        end
    end
endmodule

// File: rtl/tsiso_vm_fuse.sv
// Module: min-sum vector/matrix update.
// MAT_LEFT = 0: forward update y[j] = min_i (v[i] + m[i][j]).
// MAT_LEFT = 1: backward update y[i] = min_j (m[i][j] + v[j]).
// Assumes the all-ones code means "no path"; additions saturate to it.
module tsiso_vm_fuse #(
    parameter int NS       = 4,
    parameter int W        = 8,
    parameter bit MAT_LEFT = 1'b0
) (
    input  logic [W-1:0] v_i [NS],
    input  logic [W-1:0] m_i [NS][NS],
    output logic [W-1:0] y_o [NS]
);
    localparam logic [W-1:0] INF = '1;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (x == INF || y == INF || s >= {1'b0, INF}) return INF;
        return s[W-1:0];
    endfunction

    generate
        if (MAT_LEFT) begin : g_bwd
            // Backward: fold the right-edge vector into each row.
            always_comb begin
                logic [W-1:0] best;
                logic [W-1:0] cand;
                for (int i = 0; i < NS; i++) begin
                    best = INF;
                    for (int j = 0; j < NS; j++) begin
                        cand = sat_add(m_i[i][j], v_i[j]);
                        if (cand < best) best = cand;
                    end
                    y_o[i] = best;
                end
            end
        end else begin : g_fwd
            // Forward: fold the left-edge vector into each column.
            always_comb begin
                logic [W-1:0] best;
                logic [W-1:0] cand;
                for (int j = 0; j < NS; j++) begin
                    best = INF;
                    for (int i = 0; i < NS; i++) begin
                        cand = sat_add(v_i[i], m_i[i][j]);
                        if (cand < best) best = cand;
                    end
                    y_o[j] = best;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tsiso_vec_norm.sv
// Module: subtracts the smallest entry of a metric vector from its finite entries.
// Assumes the all-ones code means "no path" and is left unchanged.
module tsiso_vec_norm #(
    parameter int NS = 4,
    parameter int W  = 8
) (
    input  logic [W-1:0] v_i [NS],
    output logic [W-1:0] y_o [NS]
);
    localparam logic [W-1:0] INF = '1;

    // Find the minimum, then rebase every finite entry on it.
    always_comb begin
        logic [W-1:0] mn;
        mn = INF;
        for (int s = 0; s < NS; s++) begin
            if (v_i[s] < mn) mn = v_i[s];
        end
        for (int s = 0; s < NS; s++) begin
            y_o[s] = (v_i[s] == INF) ? INF : (v_i[s] - mn);
        end
    end
endmodule

// File: rtl/tsiso_metric_tree.sv
// Module: tree-structured forward/backward state metric engine.
// Holds, per time point, a "left" span matrix (block start -> point) and a
// "right" span matrix (point -> block end). Each merge stage doubles the span,
// fusing only the half of the matrices that crosses the block midpoint; one
// shared set of fusion units serves every stage. The last stage turns the
// matrices into normalised vectors through vector/matrix updates.
// Assumes N is a power of two and N >= 2. Inputs are sampled on start only.
module tsiso_metric_tree #(
    parameter int N  = 8,
    parameter int NS = 4,
    parameter int W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [N*NS*NS*W-1:0]      gamma_i,
    input  logic [NS*W-1:0]           fwd_init_i,
    input  logic [NS*W-1:0]           bwd_init_i,
    output logic                      done_o,
    output logic [(N+1)*NS*W-1:0]     fwd_o,
    output logic [(N+1)*NS*W-1:0]     bwd_o
);
    import tsiso_pkg::*;

    localparam int L    = $clog2(N);
    localparam int IW   = (L < 1) ? 1 : L;
    localparam int HALF = N / 2;

    phase_t          ph_q;
    logic [IW-1:0]   cnt_q;
    logic            done_q;
    logic            run_w;
    logic            load, merge, fin;

    logic [W-1:0]    gin    [N][NS][NS];
    logic [W-1:0]    a0_in  [NS];
    logic [W-1:0]    b0_in  [NS];
    logic [W-1:0]    a0_q   [NS];
    logic [W-1:0]    b0_q   [NS];
    logic [W-1:0]    lm_w   [N][NS][NS];
    logic [W-1:0]    rm_w   [N][NS][NS];
    logic [W-1:0]    a_mid  [NS];
    logic [W-1:0]    b_mid  [NS];
    logic [W-1:0]    a0_n   [NS];
    logic [W-1:0]    bN_n   [NS];
    logic [W-1:0]    f0_q   [NS];
    logic [W-1:0]    bN_q   [NS];

    assign run_w  = (ph_q == PH_RUN);
    assign load   = start_i && (ph_q == PH_IDLE);
    assign merge  = run_w && (cnt_q != IW'(L - 1));
    assign fin    = run_w && (cnt_q == IW'(L - 1));
    assign done_o = done_q;

    // Unpack the flat input buses.
    genvar gk, gi, gj;
    generate
        for (gk = 0; gk < N; gk++) begin : g_unpk
            for (gi = 0; gi < NS; gi++) begin : g_row
                for (gj = 0; gj < NS; gj++) begin : g_col
                    assign gin[gk][gi][gj] = gamma_i[((gk*NS+gi)*NS+gj)*W +: W];
                end
            end
        end
        for (gi = 0; gi < NS; gi++) begin : g_init
            assign a0_in[gi] = fwd_init_i[gi*W +: W];
            assign b0_in[gi] = bwd_init_i[gi*W +: W];
        end
    endgenerate

    // Controller: phase, stage counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (load) begin
            ph_q   <= PH_RUN;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (fin) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
        end else if (merge) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Capture the edge vectors with the transition metrics.
    always_ff @(posedge clk) begin
        if (load) begin
            a0_q <= a0_in;
            b0_q <= b0_in;
        end
    end

    // Midpoint vectors for the final stage: left half feeds right half.
    tsiso_vm_fuse #(.NS(NS), .W(W), .MAT_LEFT(1'b0)) u_amid (
        .v_i(a0_q), .m_i(lm_w[HALF-1]), .y_o(a_mid));
    tsiso_vm_fuse #(.NS(NS), .W(W), .MAT_LEFT(1'b1)) u_bmid (
        .v_i(b0_q), .m_i(rm_w[HALF]), .y_o(b_mid));

    tsiso_vec_norm #(.NS(NS), .W(W)) u_n_f0 (.v_i(a0_q), .y_o(a0_n));
    tsiso_vec_norm #(.NS(NS), .W(W)) u_n_bN (.v_i(b0_q), .y_o(bN_n));

    // Edge vectors of the output: forward t = 0 and backward t = N.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f0_q <= '{default: '0};
            bN_q <= '{default: '0};
        end else if (fin) begin
            f0_q <= a0_n;
            bN_q <= bN_n;
        end
    end

    generate
        for (gi = 0; gi < NS; gi++) begin : g_edge_out
            assign fwd_o[gi*W +: W]          = f0_q[gi];
            assign bwd_o[(N*NS+gi)*W +: W]   = bN_q[gi];
        end
    endgenerate

    // One slice per time point p: left matrix ends at p+1, right matrix starts at p.
    genvar gp;
    generate
        for (gp = 0; gp < N; gp++) begin : g_pt
            localparam int unsigned PP = gp;
            logic          takel;
            logic [IW-1:0] srcl, srcr;
            logic [W-1:0]  lreg [NS][NS];
            logic [W-1:0]  rreg [NS][NS];
            logic [W-1:0]  la   [NS][NS];
            logic [W-1:0]  rb   [NS][NS];
            logic [W-1:0]  lo   [NS][NS];
            logic [W-1:0]  ro   [NS][NS];
            logic [W-1:0]  abase[NS];
            logic [W-1:0]  bbase[NS];
            logic [W-1:0]  fraw [NS];
            logic [W-1:0]  braw [NS];
            logic [W-1:0]  fn   [NS];
            logic [W-1:0]  bn   [NS];
            logic [W-1:0]  fv   [NS];
            logic [W-1:0]  bv   [NS];

            assign lm_w[gp] = lreg;
            assign rm_w[gp] = rreg;

            // Pick the neighbour span this point merges with at the current stage.
            always_comb begin
                takel = (((PP >> cnt_q) & 32'd1) == 32'd1);
                srcl  = IW'(((PP >> cnt_q) << cnt_q) - 32'd1);
                srcr  = IW'(((PP >> cnt_q) + 32'd1) << cnt_q);
                la    = lm_w[srcl];
                rb    = rm_w[srcr];
            end

            tsiso_mm_fuse #(.NS(NS), .W(W)) u_lf (.a_i(la), .b_i(lreg), .y_o(lo));
            tsiso_mm_fuse #(.NS(NS), .W(W)) u_rf (.a_i(rreg), .b_i(rb), .y_o(ro));

            // Span matrices: load one-step metrics, then fuse the crossing half.
            always_ff @(posedge clk) begin
                if (load) begin
                    lreg <= gin[gp];
                    rreg <= gin[gp];
                end else if (merge) begin
                    if (takel)  lreg <= lo;
                    if (!takel) rreg <= ro;
                end
            end

            if (gp + 1 <= HALF) begin : g_abase_edge
                assign abase = a0_q;
            end else begin : g_abase_mid
                assign abase = a_mid;
            end
            if (gp >= HALF) begin : g_bbase_edge
                assign bbase = b0_q;
            end else begin : g_bbase_mid
                assign bbase = b_mid;
            end

            tsiso_vm_fuse #(.NS(NS), .W(W), .MAT_LEFT(1'b0)) u_fv (
                .v_i(abase), .m_i(lreg), .y_o(fraw));
            tsiso_vm_fuse #(.NS(NS), .W(W), .MAT_LEFT(1'b1)) u_bv (
                .v_i(bbase), .m_i(rreg), .y_o(braw));
            tsiso_vec_norm #(.NS(NS), .W(W)) u_fn (.v_i(fraw), .y_o(fn));
            tsiso_vec_norm #(.NS(NS), .W(W)) u_bn (.v_i(braw), .y_o(bn));

            // Output vectors: written only on the completing edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fv <= '{default: '0};
                    bv <= '{default: '0};
                end else if (fin) begin
                    fv <= fn;
                    bv <= bn;
                end
            end

            for (gi = 0; gi < NS; gi++) begin : g_out
                assign fwd_o[((gp+1)*NS+gi)*W +: W] = fv[gi];
                assign bwd_o[(gp*NS+gi)*W +: W]     = bv[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/tsiso_metric_tree_chk.sv
// Module: protocol and output-shape checker for tsiso_metric_tree.
// Assumes run_i is high exactly while the engine is computing.
module tsiso_metric_tree_chk #(
    parameter int N  = 8,
    parameter int NS = 4,
    parameter int W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  run_i,
    input logic                  done_o,
    input logic [(N+1)*NS*W-1:0] fwd_o,
    input logic [(N+1)*NS*W-1:0] bwd_o
);
    localparam int L = $clog2(N);
    localparam logic [W-1:0] INF = '1;

    logic [7:0] elapsed;
    logic       norm_ok;

    // Edges since the last accepted start, held once past the expected latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                     elapsed <= '0;
        else if (start_i && !run_i)     elapsed <= '0;
        else if (elapsed != 8'(L + 1))  elapsed <= elapsed + 8'd1;
    end

    // Each output vector has a zero minimum or is entirely the no-path code.
    always_comb begin
        logic [W-1:0] mf, mb;
        norm_ok = 1'b1;
        for (int t = 0; t <= N; t++) begin
            mf = INF;
            mb = INF;
            for (int s = 0; s < NS; s++) begin
                if (fwd_o[(t*NS+s)*W +: W] < mf) mf = fwd_o[(t*NS+s)*W +: W];
                if (bwd_o[(t*NS+s)*W +: W] < mb) mb = bwd_o[(t*NS+s)*W +: W];
            end
            if (mf != '0 && mf != INF) norm_ok = 1'b0;
            if (mb != '0 && mb != INF) norm_ok = 1'b0;
        end
    end

    a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (elapsed == 8'(L)));

    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_i) |=> (!done_o && run_i));

    a_r3_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r6_run_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_i) |-> $rose(done_o));

    a_r4_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> norm_ok);

    a_r8_outputs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> ($stable(fwd_o) && $stable(bwd_o)));
endmodule

bind tsiso_metric_tree tsiso_metric_tree_chk #(.N(N), .NS(NS), .W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .run_i  (run_w),
    .done_o (done_o),
    .fwd_o  (fwd_o),
    .bwd_o  (bwd_o)
);

// File: tb/tsiso_metric_tree_bench.sv
// Bench: drives an 8-step and a 16-step engine with seeded random and directed
// cases and compares every output vector with a sequential min-sum model.
module tsiso_metric_tree_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 4;
    localparam int W   = 8;
    localparam int INF = 255;

    logic clk = 1'b0;
    logic rst_n;
    logic s8, s16;
    logic [8*NS*NS*W-1:0]  gb8;
    logic [16*NS*NS*W-1:0] gb16;
    logic [NS*W-1:0]       fib, bib;
    logic                  d8, d16;
    logic [9*NS*W-1:0]     f8, b8;
    logic [17*NS*W-1:0]    f16, b16;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int g  [16][NS][NS];
    int a0 [NS];
    int b0 [NS];
    int ef [17][NS];
    int eb [17][NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsiso_metric_tree #(.N(8), .NS(NS), .W(W)) u_tsiso_metric_tree (
        .clk(clk), .rst_n(rst_n), .start_i(s8), .gamma_i(gb8),
        .fwd_init_i(fib), .bwd_init_i(bib), .done_o(d8), .fwd_o(f8), .bwd_o(b8));

    tsiso_metric_tree #(.N(16), .NS(NS), .W(W)) u_tsiso_metric_tree_n16 (
        .clk(clk), .rst_n(rst_n), .start_i(s16), .gamma_i(gb16),
        .fwd_init_i(fib), .bwd_init_i(bib), .done_o(d16), .fwd_o(f16), .bwd_o(b16));

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 100000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int sat(int x, int y);
        if (x >= INF || y >= INF || x + y >= INF) return INF;
        return x + y;
    endfunction

    task automatic norm_row(inout int v[NS]);
        int mn = INF;
        foreach (v[s]) if (v[s] < mn) mn = v[s];
        foreach (v[s]) if (v[s] != INF) v[s] = v[s] - mn;
    endtask

    // Sequential model of the forward and backward recursions (R1, R2, R5).
    task automatic model(int n);
        int a[NS];
        int b[NS];
        int t2[NS];
        a = a0;
        for (int t = 0; t <= n; t++) begin
            ef[t] = a;
            norm_row(ef[t]);
            if (t < n) begin
                for (int j = 0; j < NS; j++) begin
                    t2[j] = INF;
                    for (int i = 0; i < NS; i++)
                        if (sat(a[i], g[t][i][j]) < t2[j]) t2[j] = sat(a[i], g[t][i][j]);
                end
                a = t2;
            end
        end
        b = b0;
        for (int t = n; t >= 0; t--) begin
            eb[t] = b;
            norm_row(eb[t]);
            if (t > 0) begin
                for (int i = 0; i < NS; i++) begin
                    t2[i] = INF;
                    for (int j = 0; j < NS; j++)
                        if (sat(g[t-1][i][j], b[j]) < t2[i]) t2[i] = sat(g[t-1][i][j], b[j]);
                end
                b = t2;
            end
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, int t, logic [NS*W-1:0] act, int exp[NS]);
        logic [NS*W-1:0] e;
        for (int s = 0; s < NS; s++) e[s*W +: W] = W'(exp[s]);
        checks = checks + 1;
        if (act !== e) begin
            fails = fails + 1;
            $display("FAIL %s t=%0d: actual %h expected %h", req, t, act, e);
        end
    endtask

    // Fill the stimulus arrays for one case kind.
    task automatic build(int n, int kind);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < NS; i++)
                for (int j = 0; j < NS; j++) begin
                    case (kind)
                        0, 3: g[k][i][j] = (j == (2*i) % NS || j == (2*i+1) % NS)
                                           ? int'($urandom % 16) : INF;
                        1:    g[k][i][j] = int'($urandom % 32);
                        default: g[k][i][j] = 200 + int'($urandom % 55);
                    endcase
                end
        if (kind == 3)
            for (int i = 0; i < NS; i++)
                for (int j = 0; j < NS; j++) g[n/2-1][i][j] = INF;
        for (int s = 0; s < NS; s++) begin
            a0[s] = (kind == 1) ? int'($urandom % 20) : ((s == 0) ? 0 : INF);
            b0[s] = (kind == 1) ? int'($urandom % 20) : 0;
        end
    endtask

    task automatic drive_bus(int n, bit junk);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < NS; i++)
                for (int j = 0; j < NS; j++) begin
                    logic [W-1:0] v;
                    v = junk ? W'($urandom % 7) : W'(g[k][i][j]);
                    if (n == 8) gb8[((k*NS+i)*NS+j)*W +: W] = v;
                    else        gb16[((k*NS+i)*NS+j)*W +: W] = v;
                end
        for (int s = 0; s < NS; s++) begin
            fib[s*W +: W] = junk ? W'(INF) : W'(a0[s]);
            bib[s*W +: W] = junk ? W'(INF) : W'(b0[s]);
        end
    endtask

    // mode 0: plain; 1: inputs scrambled after capture (R7); 2: start during run (R6).
    task automatic run_case(int n, int kind, int mode, string tag);
        int lg = $clog2(n);
        logic [NS*W-1:0] hold_f, hold_b;
        build(n, kind);
        model(n);
        @(negedge clk);
        drive_bus(n, 1'b0);
        if (n == 8) s8 = 1'b1; else s16 = 1'b1;
        @(negedge clk);
        s8 = 1'b0; s16 = 1'b0;
        check_bit({"R3 done low after accept ", tag}, (n == 8) ? d8 : d16, 1'b0);
        if (mode != 0) drive_bus(n, 1'b1);
        for (int i = 1; i < lg; i++) begin
            if (i == 1 && mode == 2) begin
                if (n == 8) s8 = 1'b1; else s16 = 1'b1;
            end
            @(negedge clk);
            s8 = 1'b0; s16 = 1'b0;
        end
        check_bit({"R3 done not early ", tag}, (n == 8) ? d8 : d16, 1'b0);
        @(negedge clk);
        check_bit({"R3 done on time ", tag}, (n == 8) ? d8 : d16, 1'b1);
        for (int t = 0; t <= n; t++) begin
            if (n == 8) begin
                check_vec({"R1 fwd ", tag}, t, f8[t*NS*W +: NS*W], ef[t]);
                check_vec({"R2 bwd ", tag}, t, b8[t*NS*W +: NS*W], eb[t]);
            end else begin
                check_vec({"R1 fwd ", tag}, t, f16[t*NS*W +: NS*W], ef[t]);
                check_vec({"R2 bwd ", tag}, t, b16[t*NS*W +: NS*W], eb[t]);
            end
        end
        hold_f = (n == 8) ? f8[n*NS*W +: NS*W] : f16[n*NS*W +: NS*W];
        hold_b = (n == 8) ? b8[0 +: NS*W] : b16[0 +: NS*W];
        drive_bus(n, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check_bit({"R3 done held ", tag}, (n == 8) ? d8 : d16, 1'b1);
        check_bit({"R8 fwd held ", tag},
                  ((n == 8) ? f8[n*NS*W +: NS*W] : f16[n*NS*W +: NS*W]) == hold_f, 1'b1);
        check_bit({"R8 bwd held ", tag},
                  ((n == 8) ? b8[0 +: NS*W] : b16[0 +: NS*W]) == hold_b, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; s8 = 1'b0; s16 = 1'b0;
        gb8 = '0; gb16 = '0; fib = '0; bib = '0;
        repeat (3) @(negedge clk);
        // R9: state after reset.
        check_bit("R9 done cleared n8", d8, 1'b0);
        check_bit("R9 done cleared n16", d16, 1'b0);
        check_bit("R9 outputs cleared n8", (f8 == '0) && (b8 == '0), 1'b1);
        check_bit("R9 outputs cleared n16", (f16 == '0) && (b16 == '0), 1'b1);
        rst_n = 1'b1;

        run_case(8,  0, 0, "sparse known start n8");
        run_case(16, 0, 0, "sparse known start n16");
        run_case(8,  1, 0, "full random n8");
        run_case(16, 1, 0, "full random n16");
        run_case(8,  2, 0, "R5 saturation n8");
        run_case(16, 2, 0, "R5 saturation n16");
        run_case(8,  3, 0, "R4 blocked step n8");
        run_case(16, 3, 0, "R4 blocked step n16");
        run_case(8,  1, 1, "R7 inputs scrambled n8");
        run_case(16, 0, 1, "R7 inputs scrambled n16");
        run_case(8,  0, 2, "R6 start ignored n8");
        run_case(16, 1, 2, "R6 start ignored n16");
        for (int r = 0; r < 8; r++)
            run_case((r % 2 == 0) ? 8 : 16, r % 3, 0, "random mix");

        // R9: reset in the middle of a completed state clears outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R9 done cleared again", d8, 1'b0);
        check_bit("R9 outputs cleared again", (f16 == '0) && (b8 == '0), 1'b1);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule